// File: doc/BRIEF.md
# Multicycle Register-Transfer Datapath

This block is the 32-bit datapath of a small load/store processor. It executes each instruction as a chain of short steps: fetch, operand read, execute, memory access and write-back. An enabled register holds the value that passes from one step to the next, so no clock cycle has to cover the whole path from instruction memory to register write.

The datapath holds the program counter and the next-PC adder. It also holds the instruction register, the two operand registers, the ALU result register, the load data register and the equality flag. A 32-entry register file and the immediate extenders complete it. All sequencing belongs to an external controller. That controller drives one load enable per register plus the few selects that steer operands and write-back. It reads the instruction word and the equality flag back.

Instruction and data memories are separate. The datapath presents an address and a read strobe to each memory, and a write strobe with write data to the data memory. The instruction word is split into these fields: bits 31:26 opcode (decoded only by the controller), 25:21 first source `rs`, 20:16 second source or immediate target `rt`, 15:11 register destination `rd`, 15:0 immediate, and 5:0 function code.

Top module: `mc_datapath`

## Requirements
- R1: A synchronous reset, `rst` high at a rising edge, clears the PC and every staging register (instruction, A, B, result, load data, equality flag) and all register-file entries to zero.
- R2: When `ir_en` is high, `imem_rd` is high and `imem_addr` equals the PC. The instruction register (`ir_word`) loads `imem_data` at the next rising edge.
- R3: `a_en` loads A from register `rs` (bits 25:21) and `b_en` loads B from register `rt` (bits 20:16). `e_en` loads the equality flag `eq_flag` with 1 exactly when those two register values are equal.
- R4: The ALU mode `alu_op` selects add (0), subtract (1), function-field decode (2) or bitwise OR (3). In decode mode the function field (bits 5:0) selects 0x23 subtract, 0x24 AND, 0x25 OR; 0x21 and every other value add.
- R5: The second ALU operand `src2_sel` is B (0), the immediate zero-extended (1) or the immediate sign-extended (2). `s_en` loads the result register with the ALU output.
- R6: With `rf_wr` high, the register file is written at the next edge. The destination is `rd` when `dst_rd` is 1 and `rt` otherwise. The data is the load data register when `wb_mem` is 1 and the result register otherwise.
- R7: `m_en` drives `dmem_rd` high and loads the load data register from `dmem_rdata` at the next edge. The data address `dmem_addr` is always the result register.
- R8: `mem_wr` drives `dmem_wr` high. The write data `dmem_wdata` is always B.
- R9: With `pc_en` high, the PC becomes PC+4 when `pc_br` is low or the equality flag is clear. When `pc_br` is high and the flag is set, it becomes PC+4 plus the sign-extended immediate shifted left by two.
- R10: Register 0 reads as zero; writes to it have no effect.
- R11: A register whose enable is low keeps its value, and the register file is unchanged while `rf_wr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pc_en | input | 1 | PC load enable |
| pc_br | input | 1 | PC takes branch target when equality flag is set |
| ir_en | input | 1 | Instruction register load enable and fetch strobe |
| a_en | input | 1 | Operand A load enable |
| b_en | input | 1 | Operand B load enable |
| e_en | input | 1 | Equality flag load enable |
| s_en | input | 1 | Result register load enable |
| m_en | input | 1 | Load data register enable and data read strobe |
| rf_wr | input | 1 | Register file write enable |
| dst_rd | input | 1 | Write destination: 1 = rd, 0 = rt |
| wb_mem | input | 1 | Write data: 1 = load data, 0 = result |
| src2_sel | input | 2 | Second ALU operand select |
| alu_op | input | 2 | ALU mode |
| mem_wr | input | 1 | Data memory write request |
| imem_addr | output | 32 | Instruction memory address (PC) |
| imem_rd | output | 1 | Instruction memory read strobe |
| imem_data | input | 32 | Instruction memory read data |
| dmem_addr | output | 32 | Data memory address (result register) |
| dmem_wdata | output | 32 | Data memory write data (operand B) |
| dmem_rdata | input | 32 | Data memory read data |
| dmem_rd | output | 1 | Data memory read strobe |
| dmem_wr | output | 1 | Data memory write strobe |
| ir_word | output | 32 | Instruction register contents |
| eq_flag | output | 1 | Equality flag |

## Verification
The final step of a store raises the data write strobe and advances the PC at the same edge. The final step of an arithmetic, immediate or load instruction writes the register file and advances the PC together. The bench acts as the controller and issues both combinations in every such instruction. It judges the write strobe, address and data just before the edge, and the PC at the following fetch address. Register contents are then brought out through store instructions and compared with a reference register model.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ALU_ADD   = 2'd0,
        ALU_SUB   = 2'd1,
        ALU_FUNCT = 2'd2,
        ALU_OR    = 2'd3
    } alu_mode_e;

    typedef enum logic [1:0] {
        OPB_REG  = 2'd0,
        OPB_ZEXT = 2'd1,
        OPB_SEXT = 2'd2,
        OPB_RSVD = 2'd3
    } opb_sel_e;

    typedef enum logic [1:0] {
        K_ADD,
        K_SUB,
        K_AND,
        K_OR
    } alu_kind_e;

    localparam logic [5:0] FN_ADD = 6'h21;
    localparam logic [5:0] FN_SUB = 6'h23;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;

    typedef struct packed {
        logic [WORD_W-1:0] pc;
        logic [WORD_W-1:0] ir;
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
        logic [WORD_W-1:0] s;
        logic [WORD_W-1:0] m;
        logic              e;
    } stage_t;

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int NREG = 32,
    parameter int DW   = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [DW-1:0] rd1,
    output logic [DW-1:0] rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd
);

    logic [DW-1:0] regs_q [NREG];
    logic [DW-1:0] regs_d [NREG];

    always_comb begin
        regs_d = regs_q;
        if (we && (wa != '0)) begin
            regs_d[wa] = wd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];

    AST_RF_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (we && (wa != '0)) |=> (regs_q[$past(wa)] == $past(wd))); // R6

endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b_reg,
    input  logic [15:0]   imm,
    input  logic [1:0]    opb_sel,
    input  logic [1:0]    alu_mode,
    input  logic [5:0]    funct,
    output logic [DW-1:0] y
);

    logic [DW-1:0] opb;
    alu_kind_e     kind;

    always_comb begin
        case (opb_sel_e'(opb_sel))
            OPB_ZEXT: opb = {{(DW-16){1'b0}}, imm};
            OPB_SEXT: opb = {{(DW-16){imm[15]}}, imm};
            default:  opb = b_reg;
        endcase

        case (alu_mode_e'(alu_mode))
            ALU_SUB: kind = K_SUB;
            ALU_OR:  kind = K_OR;
            ALU_FUNCT: begin
                case (funct)
                    FN_SUB:  kind = K_SUB;
                    FN_AND:  kind = K_AND;
                    FN_OR:   kind = K_OR;
                    default: kind = K_ADD;
                endcase
            end
            default: kind = K_ADD;
        endcase

        case (kind)
            K_SUB:   y = a - opb;
            K_AND:   y = a & opb;
            K_OR:    y = a | opb;
            default: y = a + opb;
        endcase
    end

endmodule

// File: rtl/mc_nextpc.sv
module mc_nextpc #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] pc,
    input  logic [15:0]   imm,
    input  logic          take,
    output logic [DW-1:0] pc_nx
);

    logic [DW-1:0] seq;
    logic [DW-1:0] offs;

    always_comb begin
        seq   = pc + DW'(4);
        offs  = {{(DW-18){imm[15]}}, imm, 2'b00};
        pc_nx = take ? (seq + offs) : seq;
    end

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mc_pkg::*;
#(
    parameter int NREG = 32,
    localparam int DW  = WORD_W,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pc_en,
    input  logic          pc_br,
    input  logic          ir_en,
    input  logic          a_en,
    input  logic          b_en,
    input  logic          e_en,
    input  logic          s_en,
    input  logic          m_en,
    input  logic          rf_wr,
    input  logic          dst_rd,
    input  logic          wb_mem,
    input  logic [1:0]    src2_sel,
    input  logic [1:0]    alu_op,
    input  logic          mem_wr,
    output logic [DW-1:0] imem_addr,
    output logic          imem_rd,
    input  logic [DW-1:0] imem_data,
    output logic [DW-1:0] dmem_addr,
    output logic [DW-1:0] dmem_wdata,
    input  logic [DW-1:0] dmem_rdata,
    output logic          dmem_rd,
    output logic          dmem_wr,
    output logic [DW-1:0] ir_word,
    output logic          eq_flag
);

    stage_t cur_q;
    stage_t nxt_d;

    logic [AW-1:0] rs_f;
    logic [AW-1:0] rt_f;
    logic [AW-1:0] rd_f;
    logic [15:0]   imm_f;
    logic [5:0]    fn_f;

    assign rs_f  = cur_q.ir[21 +: AW];
    assign rt_f  = cur_q.ir[16 +: AW];
    assign rd_f  = cur_q.ir[11 +: AW];
    assign imm_f = cur_q.ir[15:0];
    assign fn_f  = cur_q.ir[5:0];

    logic [DW-1:0] rf_a;
    logic [DW-1:0] rf_b;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] alu_y;
    logic [DW-1:0] pc_nx;

    assign wr_addr = dst_rd ? rd_f : rt_f;
    assign wr_data = wb_mem ? cur_q.m : cur_q.s;

    mc_regfile #(.NREG(NREG), .DW(DW)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (rs_f),
        .ra2 (rt_f),
        .rd1 (rf_a),
        .rd2 (rf_b),
        .we  (rf_wr),
        .wa  (wr_addr),
        .wd  (wr_data)
    );

    mc_alu #(.DW(DW)) u_alu (
        .a        (cur_q.a),
        .b_reg    (cur_q.b),
        .imm      (imm_f),
        .opb_sel  (src2_sel),
        .alu_mode (alu_op),
        .funct    (fn_f),
        .y        (alu_y)
    );

    mc_nextpc #(.DW(DW)) u_npc (
        .pc    (cur_q.pc),
        .imm   (imm_f),
        .take  (pc_br && cur_q.e),
        .pc_nx (pc_nx)
    );

    always_comb begin
        nxt_d = cur_q;
        if (pc_en) nxt_d.pc = pc_nx;
        if (ir_en) nxt_d.ir = imem_data;
        if (a_en)  nxt_d.a  = rf_a;
        if (b_en)  nxt_d.b  = rf_b;
        if (e_en)  nxt_d.e  = (rf_a == rf_b);
        if (s_en)  nxt_d.s  = alu_y;
        if (m_en)  nxt_d.m  = dmem_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign imem_addr  = cur_q.pc;
    assign imem_rd    = ir_en;
    assign dmem_addr  = cur_q.s;
    assign dmem_wdata = cur_q.b;
    assign dmem_rd    = m_en;
    assign dmem_wr    = mem_wr;
    assign ir_word    = cur_q.ir;
    assign eq_flag    = cur_q.e;

    AST_IR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        ir_en |=> (ir_word == $past(imem_data))); // R2
    AST_EQ_MATCHES_OPS: assert property (@(posedge clk) disable iff (rst)
        (a_en && b_en && e_en) |=> (eq_flag == (cur_q.a == cur_q.b))); // R3
    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        m_en |=> (cur_q.m == $past(dmem_rdata))); // R7
    AST_PC_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (pc_en && !pc_br) |=> (imem_addr == $past(imem_addr) + DW'(4))); // R9
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pc_en |=> $stable(imem_addr)); // R11
    AST_ZERO_REG_OPERAND: assert property (@(posedge clk) disable iff (rst)
        (a_en && (rs_f == '0)) |=> (cur_q.a == '0)); // R10

endmodule

// File: tb/mc_datapath_bench.sv
module mc_datapath_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] OP_R   = 6'h00;
    localparam logic [5:0] OP_BEQ = 6'h04;
    localparam logic [5:0] OP_ORI = 6'h0d;
    localparam logic [5:0] OP_LW  = 6'h23;
    localparam logic [5:0] OP_SW  = 6'h2b;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pc_en, pc_br, ir_en, a_en, b_en, e_en, s_en, m_en;
    logic rf_wr, dst_rd, wb_mem, mem_wr;
    logic [1:0] src2_sel, alu_op;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata, ir_word;
    logic imem_rd, dmem_rd, dmem_wr, eq_flag;

    int checks = 0;
    int errors = 0;
    logic [31:0] ref_rf [32];
    logic [31:0] pc_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_datapath u_mc_datapath (
        .clk(clk), .rst(rst), .pc_en(pc_en), .pc_br(pc_br), .ir_en(ir_en),
        .a_en(a_en), .b_en(b_en), .e_en(e_en), .s_en(s_en), .m_en(m_en),
        .rf_wr(rf_wr), .dst_rd(dst_rd), .wb_mem(wb_mem), .src2_sel(src2_sel),
        .alu_op(alu_op), .mem_wr(mem_wr), .imem_addr(imem_addr), .imem_rd(imem_rd),
        .imem_data(imem_data), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_rdata(dmem_rdata), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
        .ir_word(ir_word), .eq_flag(eq_flag)
    );

    function automatic logic [31:0] sx16(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] alu_ref(input logic [31:0] x, input logic [31:0] y,
                                             input logic [5:0] fn);
        case (fn)
            6'h23:   return x - y;
            6'h24:   return x & y;
            6'h25:   return x | y;
            default: return x + y;
        endcase
    endfunction

    function automatic logic [31:0] ld_val(input logic [31:0] addr);
        return (addr * 32'h9E3779B1) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                          input logic [5:0] fn);
        return {OP_R, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                          input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ctl_clear();
        pc_en = 0; pc_br = 0; ir_en = 0; a_en = 0; b_en = 0; e_en = 0;
        s_en = 0; m_en = 0; rf_wr = 0; dst_rd = 0; wb_mem = 0; mem_wr = 0;
        src2_sel = 2'd0; alu_op = 2'd0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        ctl_clear();
    endtask

    task automatic run_instr(input logic [31:0] ins);
        logic [5:0]  op;
        logic [15:0] imm;
        logic [31:0] rs_v, rt_v, ea;
        int rs, rt, rd;
        op   = ins[31:26];
        rs   = int'(ins[25:21]);
        rt   = int'(ins[20:16]);
        rd   = int'(ins[15:11]);
        imm  = ins[15:0];
        rs_v = ref_rf[rs];
        rt_v = ref_rf[rt];
        // fetch
        imem_data = ins; ir_en = 1; #1;
        check32("R2 R9 fetch address", imem_addr, pc_m);
        check32("R2 fetch strobe", 32'(imem_rd), 32'd1);
        tick();
        check32("R2 instruction register", ir_word, ins);
        // operand read
        a_en = 1; b_en = 1; e_en = 1;
        tick();
        case (op)
            OP_R: begin
                alu_op = 2'd2; src2_sel = 2'd0; s_en = 1; tick();
                rf_wr = 1; dst_rd = 1; pc_en = 1; tick();
                if (rd != 0) ref_rf[rd] = alu_ref(rs_v, rt_v, ins[5:0]);
                pc_m = pc_m + 4;
            end
            OP_ORI: begin
                alu_op = 2'd3; src2_sel = 2'd1; s_en = 1; tick();
                rf_wr = 1; pc_en = 1; tick();
                if (rt != 0) ref_rf[rt] = rs_v | {16'h0, imm};
                pc_m = pc_m + 4;
            end
            OP_LW: begin
                alu_op = 2'd0; src2_sel = 2'd2; s_en = 1; tick();
                ea = rs_v + sx16(imm);
                m_en = 1; dmem_rdata = ld_val(ea); #1;
                check32("R7 R5 load address", dmem_addr, ea);
                check32("R7 load strobe", 32'(dmem_rd), 32'd1);
                tick();
                dmem_rdata = 32'hDEAD_BEEF;
                rf_wr = 1; wb_mem = 1; pc_en = 1; tick();
                if (rt != 0) ref_rf[rt] = ld_val(ea);
                pc_m = pc_m + 4;
            end
            OP_SW: begin
                alu_op = 2'd0; src2_sel = 2'd2; s_en = 1; tick();
                ea = rs_v + sx16(imm);
                mem_wr = 1; pc_en = 1; #1;
                check32("R8 write strobe", 32'(dmem_wr), 32'd1);
                check32("R8 R5 store address", dmem_addr, ea);
                check32("R8 R3 R6 store data", dmem_wdata, rt_v);
                tick();
                pc_m = pc_m + 4;
            end
            default: begin
                check32("R3 equality flag", 32'(eq_flag), 32'(rs_v == rt_v));
                pc_en = 1; pc_br = 1; tick();
                pc_m = (rs_v == rt_v) ? pc_m + 4 + (sx16(imm) << 2) : pc_m + 4;
            end
        endcase
    endtask

    task automatic dump_regs();
        for (int r = 0; r < 32; r++) begin
            run_instr(enc_i(OP_SW, 0, r, 16'(r * 4)));
        end
    endtask

    function automatic logic [31:0] rand_instr();
        int kind;
        logic [5:0] fns [5];
        fns[0] = 6'h21; fns[1] = 6'h23; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h00;
        kind = int'($urandom_range(0, 4));
        case (kind)
            0: return enc_r(int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                            int'($urandom_range(0, 7)), fns[$urandom_range(0, 4)]);
            1: return enc_i(OP_ORI, int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                            16'($urandom));
            2: return enc_i(OP_LW, int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                            16'($urandom));
            3: return enc_i(OP_SW, int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                            16'($urandom));
            default: begin
                int a;
                a = int'($urandom_range(0, 7));
                return enc_i(OP_BEQ, a, ($urandom_range(0, 1) == 1) ? a : int'($urandom_range(0, 7)),
                             16'($urandom_range(0, 65535)));
            end
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] last_ir;
        void'($urandom(32'd20240917));
        ctl_clear();
        imem_data = '0; dmem_rdata = '0;
        for (int r = 0; r < 32; r++) ref_rf[r] = '0;
        pc_m = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check32("R1 pc after reset", imem_addr, 32'd0);
        check32("R1 ir after reset", ir_word, 32'd0);
        check32("R1 result after reset", dmem_addr, 32'd0);
        check32("R1 operand B after reset", dmem_wdata, 32'd0);
        check32("R1 flag after reset", 32'(eq_flag), 32'd0);
        dump_regs();

        // R10 write to register 0 is dropped
        run_instr(enc_i(OP_ORI, 0, 0, 16'hFFFF));
        run_instr(enc_i(OP_SW, 0, 0, 16'h0040));

        // R5 zero extension versus sign extension
        run_instr(enc_i(OP_ORI, 0, 1, 16'h8001));
        run_instr(enc_i(OP_LW, 1, 2, 16'hFFF0));
        run_instr(enc_r(1, 2, 3, 6'h23));   // R4 subtract
        run_instr(enc_r(1, 2, 4, 6'h24));   // R4 and
        run_instr(enc_r(3, 4, 5, 6'h25));   // R4 or
        run_instr(enc_r(3, 4, 6, 6'h3F));   // R4 unlisted function adds

        // R9 branch taken backwards, then not taken
        run_instr(enc_i(OP_BEQ, 0, 0, 16'hFFFD));
        run_instr(enc_i(OP_BEQ, 1, 2, 16'h0010));
        run_instr(enc_i(OP_BEQ, 5, 5, 16'h0007));

        // R11 idle cycles: nothing loads without its enable
        last_ir = ir_word;
        for (int k = 0; k < 3; k++) begin
            imem_data = $urandom; dmem_rdata = $urandom;
            tick();
        end
        check32("R11 pc held", imem_addr, pc_m);
        check32("R11 ir held", ir_word, last_ir);

        for (int n = 0; n < 400; n++) begin
            run_instr(rand_instr());
        end
        dump_regs();   // R3 R4 R5 R6 R10 R11 final register contents

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule